// File: doc/BRIEF.md
# Codec Power-Down Sequencing Controller

This block holds the power-down request word of an audio codec and turns it into registered enable signals for seven subsections. Four are analog: the ADC, the DAC, the analog mixer and the voltage reference. The other three are the serial link, the internal clock and the headphone driver. Software reaches the request word through a small write/read port. The same word, when read, also returns the live ready flags of the four analog subsections.

Requests are not applied blindly. The reference and the mixer stay up until both converters have been released. The internal clock stays up until both converters and the link are down. The clock and the link together wait until every analog subsection that has been asked to run reports ready. No enable may rise before the reference reports ready. A request that an interlock blocks stays in the register and takes effect by itself once its condition is met. A second register at its own address carries a digital ADC-to-DAC loopback enable.

Top module: `codec_pwr_seq`

## Requirements
- R1: After reset every request bit, the loopback enable and all seven enables are 0, and both registers read back as 0 apart from the live ready field.
- R2: A write to the control address stores wdata[14:8] as requests (bit 8 ADC, 9 DAC, 10 mixer, 11 reference, 12 link, 13 clock, 14 headphone). A read returns the requests in bits 14:8, returns 0 in bits 15 and 7:4, and returns the ready inputs rdy_i[0..3] (ADC, DAC, mixer, reference) in bits 3:0. Enable output pwr_en_o[k] belongs to control bit k+8.
- R3: Written values in bits 15 and 7:0 of the control word have no effect on the readback or on the enables.
- R4: A reference request powers down the reference and the mixer only while the ADC and DAC requests are both set. Until then it stays latched and takes effect automatically once they are.
- R5: A clock request takes effect only while the ADC, DAC and link are all powered down.
- R6: While both the clock and the link are requested, neither goes down until every analog subsection that is not being powered down reports ready.
- R7: Apart from the reference, an enable rises only at an edge where rdy_i[3] was 1. An enable that is already on stays on if that flag later drops.
- R8: The enables are registered. They change at the first rising edge after the edge that stores a write or that samples a ready change.
- R9: With all seven request bits set (standby), every enable goes to 0.
- R10: A write to the general-purpose address stores wdata[7] as the loopback enable, which drives loopback_o. That register reads back with only bit 7 meaningful and all other bits 0.
- R11: A write to any other address changes nothing, and a read of any other address returns 0.
- R12: The ADC, DAC, mixer, headphone and link requests act individually and in combination, each disabling only its own subsection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Register index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for addr |
| rdy_i | input | 4 | Ready flags: ADC, DAC, mixer, reference |
| pwr_en_o | output | 7 | Subsection enables: ADC, DAC, mixer, reference, link, clock, headphone |
| loopback_o | output | 1 | Digital ADC-to-DAC loopback enable |

## Verification
The bench builds the block with its default parameters: a 7-bit index, the control word at 26h and the general-purpose register at 20h. The ready flags come from counter models with different delays per subsection (ADC 3, DAC 4, mixer 2, reference 6). Because the delays differ, the reference comes up last of the analog parts. This exposes the window in which the other enables must wait for it, and the window in which a pending mixer power-up must hold off a combined clock and link request.

// File: rtl/codec_pwr_pkg.sv
`timescale 1ns/1ps
package codec_pwr_pkg;
  localparam int WORD_W  = 16;
  localparam int NLANE   = 7;
  localparam int NANA    = 4;
  localparam int REQ_LSB = 8;
  localparam int LB_BIT  = 7;

  // lane order follows control bits REQ_LSB upward
  localparam int L_ADC  = 0;
  localparam int L_DAC  = 1;
  localparam int L_MIX  = 2;
  localparam int L_VREF = 3;
  localparam int L_LINK = 4;
  localparam int L_CLK  = 5;
  localparam int L_HP   = 6;

  typedef logic [NLANE-1:0] lane_t;
  typedef logic [NANA-1:0]  ana_t;
endpackage

// File: rtl/codec_pwr_rst_sync.sv
`timescale 1ns/1ps
module codec_pwr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/codec_pwr_regs.sv
`timescale 1ns/1ps
module codec_pwr_regs
  import codec_pwr_pkg::*;
#(
  parameter int                ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] CTRL_IDX = 7'h26,
  parameter logic [ADDR_W-1:0] GP_IDX   = 7'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  ana_t              rdy,
  output logic [WORD_W-1:0] rdata,
  output lane_t             req,
  output logic              loopback
);
  localparam int PAD_HI = WORD_W - REQ_LSB - NLANE;
  localparam int PAD_LO = REQ_LSB - NANA;

  logic  ctrl_hit, gp_hit, ctrl_we, gp_we;
  lane_t req_d;
  logic  lb_d;
  logic  unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    ctrl_hit = (addr == CTRL_IDX);
    gp_hit   = (addr == GP_IDX);
    ctrl_we  = wr_en && ctrl_hit;
    gp_we    = wr_en && gp_hit;
    req_d    = wdata[REQ_LSB +: NLANE];
    lb_d     = wdata[LB_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req      <= '0;
      loopback <= 1'b0;
    end else begin
      if (ctrl_we) req      <= req_d;
      if (gp_we)   loopback <= lb_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (ctrl_hit) begin
      rdata = {{PAD_HI{1'b0}}, req, {PAD_LO{1'b0}}, rdy};
    end else if (gp_hit) begin
      rdata[LB_BIT] = loopback;
    end
  end
endmodule

// File: rtl/codec_pwr_interlock.sv
`timescale 1ns/1ps
module codec_pwr_interlock
  import codec_pwr_pkg::*;
(
  input  lane_t req,
  input  ana_t  rdy,
  output lane_t pd
);
  ana_t ana_pd;
  logic conv_down, settled, link_pd, clk_pd;

  always_comb begin
    conv_down      = req[L_ADC] & req[L_DAC];
    ana_pd[L_ADC]  = req[L_ADC];
    ana_pd[L_DAC]  = req[L_DAC];
    ana_pd[L_VREF] = req[L_VREF] & conv_down;
    ana_pd[L_MIX]  = req[L_MIX] | ana_pd[L_VREF];
    // every analog lane that stays up has finished powering up
    settled        = &(ana_pd | rdy);
    link_pd        = req[L_LINK] & (~req[L_CLK] | settled);
    clk_pd         = req[L_CLK] & conv_down & link_pd;
    pd             = {req[L_HP], clk_pd, link_pd, ana_pd};
  end
endmodule

// File: rtl/codec_pwr_enables.sv
`timescale 1ns/1ps
module codec_pwr_enables
  import codec_pwr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lane_t pd,
  input  logic  vref_rdy,
  output lane_t en
);
  lane_t en_d;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    if (i == L_VREF) begin : g_root
      assign en_d[i] = ~pd[i];
    end else begin : g_dep
      // a lane may only start once the reference is ready
      assign en_d[i] = ~pd[i] & (en[i] | vref_rdy);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else        en <= en_d;
  end
endmodule

// File: rtl/codec_pwr_seq.sv
`timescale 1ns/1ps
module codec_pwr_seq
  import codec_pwr_pkg::*;
#(
  parameter int                ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] CTRL_IDX = 7'h26,
  parameter logic [ADDR_W-1:0] GP_IDX   = 7'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic [3:0]        rdy_i,
  output logic [6:0]        pwr_en_o,
  output logic              loopback_o
);
  logic  rst_int_n;
  lane_t req, pd, en;

  codec_pwr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  codec_pwr_regs #(
    .ADDR_W   (ADDR_W),
    .CTRL_IDX (CTRL_IDX),
    .GP_IDX   (GP_IDX)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdy      (rdy_i),
    .rdata    (rdata),
    .req      (req),
    .loopback (loopback_o)
  );

  codec_pwr_interlock u_lock (
    .req (req),
    .rdy (rdy_i),
    .pd  (pd)
  );

  codec_pwr_enables u_en (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pd       (pd),
    .vref_rdy (rdy_i[L_VREF]),
    .en       (en)
  );

  assign pwr_en_o = en;
endmodule

// File: rtl/codec_pwr_seq_chk.sv
`timescale 1ns/1ps
module codec_pwr_seq_chk #(
  parameter int                ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] CTRL_IDX = 7'h26,
  parameter logic [ADDR_W-1:0] GP_IDX   = 7'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wdata,
  input logic [15:0]       rdata,
  input logic [3:0]        rdy_i,
  input logic [6:0]        pwr_en_o,
  input logic              loopback_o
);
  localparam logic [6:0] DEP_MASK = 7'b1110111;

  assert_vref_needs_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en_o[3] |-> (!pwr_en_o[0] && !pwr_en_o[1] && !pwr_en_o[2]));

  assert_clk_needs_deps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en_o[5]) |-> (!pwr_en_o[0] && !pwr_en_o[1] && !pwr_en_o[4]));

  assert_rise_after_vref_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pwr_en_o & ~$past(pwr_en_o) & DEP_MASK)) |-> $past(rdy_i[3]));

  assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == CTRL_IDX) |-> (rdata[15] == 1'b0 && rdata[7:4] == 4'h0 && rdata[3:0] == rdy_i));

  assert_loopback_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == GP_IDX) |-> (loopback_o == $past(wdata[7])));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != CTRL_IDX && addr != GP_IDX) |-> (rdata == 16'h0000));
endmodule

bind codec_pwr_seq codec_pwr_seq_chk #(
  .ADDR_W   (ADDR_W),
  .CTRL_IDX (CTRL_IDX),
  .GP_IDX   (GP_IDX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .rdy_i      (rdy_i),
  .pwr_en_o   (pwr_en_o),
  .loopback_o (loopback_o)
);

// File: tb/codec_pwr_seq_test.sv
`timescale 1ns/1ps
module codec_pwr_seq_test;
  localparam logic [6:0] CTRL = 7'h26;
  localparam logic [6:0] GP   = 7'h20;
  localparam logic [6:0] OTH  = 7'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = 7'h00;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic [3:0]  rdy = 4'h0;
  logic [6:0]  pwr_en_o;
  logic        loopback_o;

  int total = 0;
  int fails = 0;

  // behavioural model state
  logic [6:0] m_req = 7'h00;
  logic       m_lb = 1'b0;
  logic [6:0] exp_en = 7'h00;
  int         m_hold = 0;
  int         cnt[4] = '{0, 0, 0, 0};
  int         dly[4] = '{3, 4, 2, 6};
  string      tag = "R1";

  codec_pwr_seq uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .rdy_i      (rdy),
    .pwr_en_o   (pwr_en_o),
    .loopback_o (loopback_o)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic check(input string t, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] model_next(input logic [6:0] r, input logic [3:0] rd,
                                            input logic [6:0] cur);
    logic [6:0] dn;
    logic [6:0] nx;
    bit ok;
    dn[0] = r[0];
    dn[1] = r[1];
    dn[3] = r[3] && r[0] && r[1];
    dn[2] = r[2] || dn[3];
    ok = 1;
    for (int i = 0; i < 4; i++) if (!dn[i] && !rd[i]) ok = 0;
    dn[4] = r[4] && (!r[5] || ok);
    dn[5] = r[5] && r[0] && r[1] && dn[4];
    dn[6] = r[6];
    for (int i = 0; i < 7; i++) begin
      if (i == 3) nx[i] = !dn[i];
      else        nx[i] = !dn[i] && (cur[i] || rd[3]);
    end
    return nx;
  endfunction

  // called at a falling edge: drive, predict the next rising edge, then compare
  task automatic step(input logic we, input logic [6:0] a, input logic [15:0] d);
    logic [6:0] nx;
    wr_en = we;
    addr  = a;
    wdata = d;
    if (m_hold > 0) begin
      nx = 7'h00;
      m_hold--;
    end else begin
      nx = model_next(m_req, rdy, exp_en);
    end
    if (we && a == CTRL) m_req = d[14:8];
    if (we && a == GP)   m_lb  = d[7];
    exp_en = nx;
    @(negedge clk);
    check(tag, {9'b0, pwr_en_o}, {9'b0, exp_en});
    check(tag, {15'b0, loopback_o}, {15'b0, m_lb});
    for (int i = 0; i < 4; i++) begin
      if (!pwr_en_o[i]) begin
        cnt[i] = 0;
        rdy[i] = 1'b0;
      end else if (cnt[i] >= dly[i]) begin
        rdy[i] = 1'b1;
      end else begin
        cnt[i]++;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 7'h00, 16'h0000);
  endtask

  task automatic rd(input logic [6:0] a, input logic [15:0] exp, input string t);
    wr_en = 1'b0;
    addr  = a;
    #1;
    check(t, rdata, exp);
  endtask

  task automatic en_is(input logic [6:0] exp, input string t);
    check(t, {9'b0, pwr_en_o}, {9'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    en_is(7'h00, "R1 enables in reset");
    check("R1 loopback in reset", {15'b0, loopback_o}, 16'h0);
    rd(CTRL, 16'h0000, "R1 control readback");
    rd(GP, 16'h0000, "R1 gp readback");
    addr = 7'h00;
    rst_n = 1'b1;
    m_hold = 2;

    // R7: reference first, others wait for its ready
    tag = "R7";
    idle(3);
    en_is(7'h08, "R7 only reference after reset");
    idle(2);
    en_is(7'h08, "R7 others held until reference ready");
    idle(20);
    en_is(7'h7F, "R7 all up after reference ready");
    rd(CTRL, 16'h000F, "R2 all ready readback");

    // R4 blocked reference request, then effective
    tag = "R4";
    step(1'b1, CTRL, 16'h0800);
    idle(10);
    en_is(7'h7F, "R4 reference request blocked");
    rd(CTRL, 16'h080F, "R4 blocked request latched");
    tag = "R3";
    step(1'b1, CTRL, 16'h8BFF);
    idle(20);
    en_is(7'h70, "R4 reference and mixer down with converters");
    rd(CTRL, 16'h0B00, "R3 status and reserved bits unaffected");

    // R8 power-up timing after write
    tag = "R8";
    step(1'b1, CTRL, 16'h0000);
    en_is(7'h70, "R8 no change at write edge");
    idle(1);
    en_is(7'h78, "R8 reference one clock after write");
    idle(20);
    en_is(7'h7F, "R8 all back up");

    // R5 clock interlock
    tag = "R5";
    step(1'b1, CTRL, 16'h2000);
    idle(5);
    en_is(7'h7F, "R5 clock blocked by converters");
    step(1'b1, CTRL, 16'h2300);
    idle(8);
    en_is(7'h7C, "R5 clock blocked by link");
    step(1'b1, CTRL, 16'h3300);
    en_is(7'h7C, "R5 unchanged at write edge");
    idle(1);
    en_is(7'h4C, "R5 clock and link down together");
    rd(CTRL, 16'h330C, "R2 request and ready readback");

    // R6 pending power-up holds clock and link
    tag = "R6";
    step(1'b1, CTRL, 16'h0700);
    idle(10);
    en_is(7'h78, "R6 converters and mixer down");
    step(1'b1, CTRL, 16'h3300);
    idle(1);
    en_is(7'h7C, "R6 link and clock held while mixer pending");
    idle(10);
    en_is(7'h4C, "R6 link and clock down after mixer ready");

    // R12 individual and combined requests
    tag = "R12";
    step(1'b1, CTRL, 16'h0000);
    idle(20);
    en_is(7'h7F, "R12 restart");
    step(1'b1, CTRL, 16'h0100); idle(10); en_is(7'h7E, "R12 adc alone");
    step(1'b1, CTRL, 16'h0200); idle(10); en_is(7'h7D, "R12 dac alone");
    step(1'b1, CTRL, 16'h0400); idle(10); en_is(7'h7B, "R12 mixer alone");
    step(1'b1, CTRL, 16'h4000); idle(10); en_is(7'h3F, "R12 headphone alone");
    step(1'b1, CTRL, 16'h0500); idle(10); en_is(7'h7A, "R12 adc and mixer");
    step(1'b1, CTRL, 16'h1000); idle(10); en_is(7'h6F, "R12 link alone");
    tag = "R5";
    step(1'b1, CTRL, 16'h3000); idle(10); en_is(7'h6F, "R5 clock held with converters up");

    // R9 standby
    tag = "R9";
    step(1'b1, CTRL, 16'h7F00);
    idle(20);
    en_is(7'h00, "R9 standby all off");
    rd(CTRL, 16'h7F00, "R9 standby readback");
    step(1'b1, CTRL, 16'h0000);
    idle(25);
    en_is(7'h7F, "R9 recovery from standby");

    // R10 loopback register
    tag = "R10";
    step(1'b1, GP, 16'hFFFF);
    check("R10 loopback set", {15'b0, loopback_o}, 16'h1);
    rd(GP, 16'h0080, "R10 gp readback");
    step(1'b1, GP, 16'h0F7F);
    check("R10 loopback clear", {15'b0, loopback_o}, 16'h0);
    rd(GP, 16'h0000, "R10 gp cleared");

    // R11 unmapped address
    tag = "R11";
    step(1'b1, OTH, 16'hFFFF);
    idle(3);
    en_is(7'h7F, "R11 enables unchanged");
    rd(CTRL, 16'h000F, "R11 control unchanged");
    rd(GP, 16'h0000, "R11 gp unchanged");
    rd(OTH, 16'h0000, "R11 unmapped reads zero");
    idle(2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule